// File: doc/BRIEF.md
# Eight-Phase Johnson Timing Sequencer

This block is the timing generator of a small processor core. A four-stage twisted-ring register steps through eight states, one step per clock edge, where each edge stands for one half-period of the core's machine timing. Every stage and its complement are brought out as eight phase signals. Each phase signal is high for four consecutive steps, and each one lags its neighbour by a single step.

Before it reaches the ring, the step is gated by three controls. Reset returns the ring to its home state. A wait request freezes the ring in whatever phase it is in. A pause request lets the ring run on to the home phase and then holds it there. A decoder turns the current phase into sixteen timing windows, each covering a fixed contiguous span of phases. A registered marker pulses once whenever the ring wraps from its last phase back to home. The rest of the core uses this marker as the end of a machine cycle.

Top module: `jseq_top`

## Requirements
- R1: A synchronous active-high `rst` seen at a rising edge puts the ring at phase 0. After that edge `seq_o` reads 8'hF0 and `cyc_end_o` is 0.
- R2: At each rising edge with `rst`, `wait_req` and the pause hold all inactive, the phase advances by one. Phase 7 is followed by phase 0.
- R3: `seq_o[k]` is high exactly in phases (k+1) to (k+4), modulo 8. This puts four bits high in every phase, and a single step changes exactly two bits of `seq_o`.
- R4: While `wait_req` is high at a rising edge, the phase does not change, whatever the phase is.
- R5: `pause_req` holds the ring only when it is at phase 0. At any other phase with `pause_req` high, the ring keeps advancing until it reaches phase 0.
- R6: `rst` takes priority over `wait_req` and `pause_req`. Wait in turn takes priority over the run/pause decision.
- R7: For n from 0 to 7, window `win_o[n]` is high in phase n only.
- R8: For n from 8 to 15, window `win_o[n]` starts at phase n-8 and spans 2 phases for even n and 3 phases for odd n. Its range wraps modulo 8.
- R9: In every phase at least one window bit is high.
- R10: `cyc_end_o` is high for exactly the one cycle after a step from phase 7 to phase 0. It stays low otherwise, including after reset and while the ring is held at phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Step clock; each rising edge is one half-period of machine timing |
| rst | input | 1 | Synchronous active-high reset to phase 0 |
| wait_req | input | 1 | Freeze the ring in its current phase |
| pause_req | input | 1 | Stop the ring once it reaches phase 0 |
| seq_o | output | 8 | Phase signals: the ring stages, then their complements |
| win_o | output | 16 | Decoded timing windows |
| cyc_end_o | output | 1 | One-cycle marker after a wrap from phase 7 to phase 0 |

## Verification
The control inputs act at the next rising edge. The phase signals and windows decode directly from the ring register, so they settle in the same cycle as that edge. The wrap marker is registered at that same edge, so it is also due one edge after the step that causes it, with no further delay. The bench changes inputs on the falling edge and predicts the state the next rising edge will produce. It compares all outputs at the following falling edge, exactly one register stage after each stimulus.

// File: rtl/jseq_pkg.sv
package jseq_pkg;

    // Number of ring stages; the ring yields twice as many phases.
    localparam int unsigned JS_STAGES = 4;

    // Per-edge action chosen by the gating logic.
    typedef enum logic [1:0] {
        STEP_RUN   = 2'd0,
        STEP_RESET = 2'd1,
        STEP_WAIT  = 2'd2,
        STEP_PAUSE = 2'd3
    } step_mode_e;

    // First phase covered by a window.
    function automatic int unsigned win_first(input int unsigned idx, input int unsigned nph);
        return idx % nph;
    endfunction

    // Span of a window in phases: single-phase windows first, then 2/3 alternating.
    function automatic int unsigned win_span(input int unsigned idx, input int unsigned nph);
        if (idx < nph)
            return 1;
        return 2 + (idx % 2);
    endfunction

endpackage

// File: rtl/jseq_gate.sv
module jseq_gate
    import jseq_pkg::*;
(
    input  logic       rst,
    input  logic       wait_req,
    input  logic       pause_req,
    input  logic       at_home,
    output step_mode_e mode
);

    // Priority: reset, then wait, then pause at home, otherwise run.
    always_comb begin
        if (rst)
            mode = STEP_RESET;
        else if (wait_req)
            mode = STEP_WAIT;
        else if (pause_req && at_home)
            mode = STEP_PAUSE;
        else
            mode = STEP_RUN;
    end

endmodule

// File: rtl/jseq_ring.sv
module jseq_ring
    import jseq_pkg::*;
#(
    parameter  int unsigned STAGES = JS_STAGES,
    localparam int unsigned NPH    = 2 * STAGES,
    localparam int unsigned PW     = $clog2(NPH)
) (
    input  logic              clk,
    input  step_mode_e        mode,
    output logic [STAGES-1:0] state,
    output logic [PW-1:0]     phase,
    output logic              at_home,
    output logic              cyc_end
);

    // Phase index of a legal twisted-ring pattern.
    function automatic logic [PW-1:0] ph_of(input logic [STAGES-1:0] s);
        int unsigned ones;
        ones = 0;
        for (int i = 0; i < STAGES; i++)
            ones += int'(s[i]);
        if (s[STAGES-1])
            return PW'((NPH - ones) % NPH);
        return PW'(ones);
    endfunction

    // Ring pattern that belongs to a phase index.
    function automatic logic [STAGES-1:0] code_of(input logic [PW-1:0] p);
        logic [STAGES-1:0] c;
        int unsigned pi;
        pi = int'(p);
        for (int i = 0; i < STAGES; i++) begin
            if (pi <= STAGES)
                c[i] = (i < pi);
            else
                c[i] = (i >= pi - STAGES);
        end
        return c;
    endfunction

    logic              legal;
    logic [STAGES-1:0] stepped;

    always_comb begin
        phase   = ph_of(state);
        legal   = (state == code_of(phase));
        at_home = (state == '0);
        // A pattern outside the ring's eight codes falls back to home.
        if (legal)
            stepped = {state[STAGES-2:0], ~state[STAGES-1]};
        else
            stepped = '0;
    end

    always_ff @(posedge clk) begin
        case (mode)
            STEP_RESET: begin
                state   <= '0;
                cyc_end <= 1'b0;
            end
            STEP_RUN: begin
                state   <= stepped;
                cyc_end <= legal && (phase == PW'(NPH - 1));
            end
            default: begin
                cyc_end <= 1'b0;
            end
        endcase
    end

    // R1
    reset_home_chk: assert property (@(posedge clk)
        (mode == STEP_RESET) |=> (state == '0 && !cyc_end));

    // R2
    advance_chk: assert property (@(posedge clk) disable iff (mode == STEP_RESET)
        (mode == STEP_RUN) |=> (int'(phase) == (int'($past(phase)) + 1) % NPH));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (mode == STEP_RESET)
        (mode == STEP_WAIT || mode == STEP_PAUSE) |=> $stable(state));

    // R3
    ring_form_chk: assert property (@(posedge clk) disable iff (mode == STEP_RESET)
        (mode == STEP_RUN) |=> legal);

    // R10
    mark_home_chk: assert property (@(posedge clk) disable iff (mode == STEP_RESET)
        cyc_end |-> at_home);

    // R10
    mark_once_chk: assert property (@(posedge clk) disable iff (mode == STEP_RESET)
        cyc_end |=> !cyc_end);

endmodule

// File: rtl/jseq_decode.sv
module jseq_decode
    import jseq_pkg::*;
#(
    parameter  int unsigned STAGES = JS_STAGES,
    localparam int unsigned NPH    = 2 * STAGES,
    localparam int unsigned NWIN   = 2 * NPH,
    localparam int unsigned PW     = $clog2(NPH)
) (
    input  logic [STAGES-1:0] state,
    input  logic [PW-1:0]     phase,
    output logic [NPH-1:0]    seq,
    output logic [NWIN-1:0]   win
);

    // Stages first, then their complements: each lags the last by one step.
    assign seq = {~state, state};

    for (genvar n = 0; n < NWIN; n++) begin : g_win
        localparam int unsigned FIRST = win_first(n, NPH);
        localparam int unsigned SPAN  = win_span(n, NPH);
        assign win[n] = ((int'(phase) + NPH - FIRST) % NPH) < SPAN;
    end

endmodule

// File: rtl/jseq_top.sv
module jseq_top
    import jseq_pkg::*;
#(
    parameter  int unsigned STAGES = JS_STAGES,
    localparam int unsigned NPH    = 2 * STAGES,
    localparam int unsigned NWIN   = 2 * NPH,
    localparam int unsigned PW     = $clog2(NPH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wait_req,
    input  logic            pause_req,
    output logic [NPH-1:0]  seq_o,
    output logic [NWIN-1:0] win_o,
    output logic            cyc_end_o
);

    step_mode_e        mode;
    logic              at_home;
    logic [STAGES-1:0] state;
    logic [PW-1:0]     phase;

    jseq_gate u_gate (
        .rst       (rst),
        .wait_req  (wait_req),
        .pause_req (pause_req),
        .at_home   (at_home),
        .mode      (mode)
    );

    jseq_ring #(.STAGES(STAGES)) u_ring (
        .clk     (clk),
        .mode    (mode),
        .state   (state),
        .phase   (phase),
        .at_home (at_home),
        .cyc_end (cyc_end_o)
    );

    jseq_decode #(.STAGES(STAGES)) u_dec (
        .state (state),
        .phase (phase),
        .seq   (seq_o),
        .win   (win_o)
    );

    // R3
    seq_weight_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(seq_o) == STAGES);

    // R3
    step_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == STEP_RUN) |=> ($countones(seq_o ^ $past(seq_o)) == 2));

    // R5
    pause_runs_chk: assert property (@(posedge clk) disable iff (rst)
        (pause_req && !wait_req && !at_home) |=> !$stable(seq_o));

    // R6
    reset_wins_chk: assert property (@(posedge clk)
        (rst && (wait_req || pause_req)) |=> (seq_o == {{STAGES{1'b1}}, {STAGES{1'b0}}}));

    // R9
    win_cover_chk: assert property (@(posedge clk) disable iff (rst)
        win_o != '0);

endmodule

// File: tb/jseq_top_test.sv
module jseq_top_test;

    localparam int NPH  = 8;
    localparam int NWIN = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wait_req = 1'b0;
    logic            pause_req = 1'b0;
    logic [NPH-1:0]  seq_o;
    logic [NWIN-1:0] win_o;
    logic            cyc_end_o;

    int    total = 0;
    int    bad = 0;
    int    exp_ph = 0;
    logic  exp_cyc = 1'b0;
    bit    armed = 1'b0;
    string step_tag = "R1";

    always #5 clk = ~clk;

    jseq_top uut (
        .clk       (clk),
        .rst       (rst),
        .wait_req  (wait_req),
        .pause_req (pause_req),
        .seq_o     (seq_o),
        .win_o     (win_o),
        .cyc_end_o (cyc_end_o)
    );

    // R3: seq bit k is high in phases k+1..k+4 mod 8
    function automatic logic [NPH-1:0] exp_seq(input int p);
        logic [NPH-1:0] v;
        for (int k = 0; k < NPH; k++)
            v[k] = ((p - k - 1 + 2 * NPH) % NPH) < 4;
        return v;
    endfunction

    // R7/R8 window table
    function automatic logic [NWIN-1:0] exp_win(input int p);
        logic [NWIN-1:0] v;
        for (int n = 0; n < NWIN; n++) begin
            int first;
            int span;
            first = n % NPH;
            span  = (n < NPH) ? 1 : (2 + n % 2);
            v[n]  = ((p - first + NPH) % NPH) < span;
        end
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h (phase %0d)", req, got, exp, exp_ph);
        end
    endtask

    task automatic check_outputs();
        logic [NWIN-1:0] w;
        w = exp_win(exp_ph);
        chk(step_tag, 32'(seq_o), 32'(exp_seq(exp_ph)));
        chk("R7 single-phase windows", 32'(win_o[7:0]), 32'(w[7:0]));
        chk("R8 wide windows", 32'(win_o[15:8]), 32'(w[15:8]));
        chk("R9 coverage", 32'(|win_o), 32'd1);
        chk("R10 wrap marker", 32'(cyc_end_o), 32'(exp_cyc));
    endtask

    // Check at the falling edge, then drive the next edge's inputs and predict it.
    task automatic tick(input logic r, input logic w, input logic p);
        @(negedge clk);
        if (armed)
            check_outputs();
        rst       = r;
        wait_req  = w;
        pause_req = p;
        if (r) begin
            exp_ph   = 0;
            exp_cyc  = 1'b0;
            step_tag = (w || p) ? "R6 reset priority" : "R1 reset state";
        end else if (w) begin
            exp_cyc  = 1'b0;
            step_tag = p ? "R6 wait over pause" : "R4 wait hold";
        end else if (p && exp_ph == 0) begin
            exp_cyc  = 1'b0;
            step_tag = "R5 pause hold";
        end else begin
            exp_cyc  = (exp_ph == NPH - 1);
            exp_ph   = (exp_ph + 1) % NPH;
            step_tag = p ? "R5 pause runs on" : "R2 R3 advance";
        end
        armed = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic pz;
        pz = 1'b0;
        void'($urandom(32'd1802));
        // reset
        repeat (3) tick(1'b1, 1'b0, 1'b0);
        // free run past two wraps
        repeat (18) tick(1'b0, 1'b0, 1'b0);
        // wait mid-cycle
        repeat (4) tick(1'b0, 1'b1, 1'b0);
        // pause from a non-home phase: runs to 0 then holds
        repeat (12) tick(1'b0, 1'b0, 1'b1);
        // wait and pause together at home
        repeat (2) tick(1'b0, 1'b1, 1'b1);
        repeat (9) tick(1'b0, 1'b0, 1'b0);
        // wait held right after a wrap
        while (exp_ph != 0) tick(1'b0, 1'b0, 1'b0);
        repeat (3) tick(1'b0, 1'b1, 1'b0);
        // reset with both holds asserted, mid-cycle
        repeat (3) tick(1'b0, 1'b0, 1'b0);
        tick(1'b1, 1'b1, 1'b1);
        repeat (4) tick(1'b0, 1'b0, 1'b0);
        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic r;
            logic w;
            r = ($urandom % 64) == 0;
            w = ($urandom % 6) == 0;
            if (($urandom % 12) == 0)
                pz = ~pz;
            tick(r, w, pz);
        end
        tick(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check_outputs();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule